// File: doc/BRIEF.md
# Downlink DC Offset Calibration and Sample Gate

This block sits on the I and Q receive paths between the decimation filter and the serial port. It learns each channel's DC offset from the filter's own output during a calibration window. It subtracts that offset from every later sample. It also decides which corrected samples go forward. Power qualification combines a path activation bit, the receive-window input and a bit that allows that window to power the path down. Calibration and transmit-enable take effect only while the path is live.

A calibration window is opened and closed by one control input. The block averages the first sixteen samples of each channel in the window and loads the result when the window closes. In internal mode the block asserts an output that shorts each differential input pair. In external mode the inputs stay connected, so the learned value also includes the DC error of the external circuitry. Forwarding starts on a transmit-enable rising edge. The first eight samples after that edge are discarded while the filter settles.

Top module: `dl_offset_gate`

## Requirements
- R1: After reset both offset registers hold zero, out_vld_o is low and both output samples are zero.
- R2: path_on_o equals path_act_i AND (dl_on_i OR NOT win_pd_en_i).
- R3: cal_i and tx_en_i have no effect unless dl_on_i and path_on_o are both high. In that state no sample is forwarded and no offset is learned.
- R4: short_o is high exactly when calibration is live (cal_i, dl_on_i and path_on_o all high) and ext_cal_i is 0, meaning internal mode. With ext_cal_i at 1 (external mode) short_o stays low.
- R5: While calibration is live, the first 16 valid samples of each channel are summed. On the cycle calibration stops being live, the offset becomes that sum arithmetically shifted right by 4 (rounding toward minus infinity), but only if all 16 samples were collected. Otherwise the old offset is kept.
- R6: Each forwarded sample equals the input minus the channel's offset, saturated to the signed range of the output width (-2048..2047 at the default 12 bits).
- R7: A forwarded sample appears on out_i_o and out_q_o with out_vld_o high on the clock edge after the edge that accepted it. The outputs hold their values while out_vld_o is low.
- R8: After each rising edge of live transmit-enable, the first 8 valid samples are dropped. The count starts again at every new rising edge.
- R9: Samples that arrive while live transmit-enable is low, or while calibration is live, are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| path_act_i | input | 1 | Path activation bit |
| win_pd_en_i | input | 1 | Lets the receive window power the path down |
| dl_on_i | input | 1 | Receive window / downlink-on |
| cal_i | input | 1 | Calibration window |
| ext_cal_i | input | 1 | 1 selects external calibration, 0 internal |
| tx_en_i | input | 1 | Transmit enable |
| sample_vld_i | input | 1 | Filter output sample valid |
| sample_i_i | input | W | I filter output, signed |
| sample_q_i | input | W | Q filter output, signed |
| path_on_o | output | 1 | Path powered |
| short_o | output | 1 | Short differential input pairs |
| out_vld_o | output | 1 | Corrected sample valid |
| out_i_o | output | W | Corrected I sample, signed |
| out_q_o | output | W | Corrected Q sample, signed |

## Verification
The assertions assume that control inputs and sample data change only between clock edges and are stable at the rising edge. They also assume that sample_vld_i is the only qualifier for sample data, so values on cycles where it is low are not constrained. The bench drives every input on the falling edge. It holds the calibration and enable levels for long random stretches, so calibration windows both reach and fall short of sixteen samples. It also mixes full-scale sample values with small ones, so saturation occurs on both rails.

// File: rtl/dl_offset_pkg.sv
package dl_offset_pkg;
  localparam int unsigned N_CH = 2;

  typedef struct packed {
    logic cal;
    logic cal_rise;
    logic cal_fall;
    logic en;
    logic en_rise;
  } ctl_t;
endpackage

// File: rtl/dl_power_ctl.sv
module dl_power_ctl
  import dl_offset_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic path_act_i,
  input  logic win_pd_en_i,
  input  logic dl_on_i,
  input  logic cal_i,
  input  logic ext_cal_i,
  input  logic tx_en_i,
  output ctl_t ctl_o,
  output logic path_on_o,
  output logic short_o
);
  logic live, cal_q, en_q, cal_prev, en_prev;

  assign path_on_o = path_act_i & (dl_on_i | ~win_pd_en_i);
  assign live      = path_on_o & dl_on_i;
  assign cal_q     = cal_i & live;
  assign en_q      = tx_en_i & live;
  assign short_o   = cal_q & ~ext_cal_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cal_prev <= 1'b0;
      en_prev  <= 1'b0;
    end else begin
      cal_prev <= cal_q;
      en_prev  <= en_q;
    end
  end

  always_comb begin
    ctl_o.cal      = cal_q;
    ctl_o.cal_rise = cal_q & ~cal_prev;
    ctl_o.cal_fall = ~cal_q & cal_prev;
    ctl_o.en       = en_q;
    ctl_o.en_rise  = en_q & ~en_prev;
  end
endmodule

// File: rtl/dl_cal_acc.sv
module dl_cal_acc #(
  parameter int unsigned W        = 12,
  parameter int unsigned CAL_LOG2 = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cal_i,
  input  logic                cal_rise_i,
  input  logic                cal_fall_i,
  input  logic                vld_i,
  input  logic signed [W-1:0] smp_i,
  output logic signed [W-1:0] off_o
);
  localparam int unsigned AW = W + CAL_LOG2;
  localparam int unsigned CW = CAL_LOG2 + 1;
  localparam int unsigned N  = 1 << CAL_LOG2;

  logic signed [AW-1:0] acc, acc_b, avg;
  logic [CW-1:0]        cnt, cnt_b;

  assign acc_b = cal_rise_i ? '0 : acc;
  assign cnt_b = cal_rise_i ? '0 : cnt;
  assign avg   = acc >>> CAL_LOG2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc   <= '0;
      cnt   <= '0;
      off_o <= '0;
    end else if (cal_i) begin
      if (vld_i && cnt_b < CW'(N)) begin
        acc <= acc_b + AW'(smp_i);
        cnt <= cnt_b + 1'b1;
      end else begin
        acc <= acc_b;
        cnt <= cnt_b;
      end
    end else if (cal_fall_i && cnt == CW'(N)) begin
      off_o <= avg[W-1:0];
    end
  end
endmodule

// File: rtl/dl_sub_sat.sv
module dl_sub_sat #(
  parameter int unsigned W = 12
) (
  input  logic signed [W-1:0] smp_i,
  input  logic signed [W-1:0] off_i,
  output logic signed [W-1:0] res_o
);
  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic signed [W:0] diff;

  assign diff = (W+1)'(smp_i) - (W+1)'(off_i);

  always_comb begin
    if (diff[W] != diff[W-1]) res_o = diff[W] ? MINV : MAXV;
    else                      res_o = diff[W-1:0];
  end
endmodule

// File: rtl/dl_settle_gate.sv
module dl_settle_gate #(
  parameter int unsigned SETTLE = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vld_i,
  input  logic en_i,
  input  logic en_rise_i,
  input  logic cal_i,
  output logic fwd_o
);
  localparam int unsigned SW = $clog2(SETTLE + 1);

  logic [SW-1:0] cnt, cnt_b;
  logic          take, done;

  assign cnt_b = en_rise_i ? '0 : cnt;
  assign take  = vld_i & en_i & ~cal_i;
  assign done  = cnt_b >= SW'(SETTLE);
  assign fwd_o = take & done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt <= '0;
    else if (take && !done) cnt <= cnt_b + 1'b1;
    else if (en_i)          cnt <= cnt_b;
  end
endmodule

// File: rtl/dl_offset_gate.sv
module dl_offset_gate
  import dl_offset_pkg::*;
#(
  parameter int unsigned W        = 12,
  parameter int unsigned CAL_LOG2 = 4,
  parameter int unsigned SETTLE   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                path_act_i,
  input  logic                win_pd_en_i,
  input  logic                dl_on_i,
  input  logic                cal_i,
  input  logic                ext_cal_i,
  input  logic                tx_en_i,
  input  logic                sample_vld_i,
  input  logic signed [W-1:0] sample_i_i,
  input  logic signed [W-1:0] sample_q_i,
  output logic                path_on_o,
  output logic                short_o,
  output logic                out_vld_o,
  output logic signed [W-1:0] out_i_o,
  output logic signed [W-1:0] out_q_o
);
  ctl_t              ctl;
  logic              fwd;
  logic signed [W-1:0] smp [N_CH];
  logic signed [W-1:0] off [N_CH];
  logic signed [W-1:0] res [N_CH];

  assign smp[0] = sample_i_i;
  assign smp[1] = sample_q_i;

  dl_power_ctl u_pwr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .path_act_i  (path_act_i),
    .win_pd_en_i (win_pd_en_i),
    .dl_on_i     (dl_on_i),
    .cal_i       (cal_i),
    .ext_cal_i   (ext_cal_i),
    .tx_en_i     (tx_en_i),
    .ctl_o       (ctl),
    .path_on_o   (path_on_o),
    .short_o     (short_o)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    dl_cal_acc #(.W(W), .CAL_LOG2(CAL_LOG2)) u_cal (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cal_i      (ctl.cal),
      .cal_rise_i (ctl.cal_rise),
      .cal_fall_i (ctl.cal_fall),
      .vld_i      (sample_vld_i),
      .smp_i      (smp[c]),
      .off_o      (off[c])
    );
    dl_sub_sat #(.W(W)) u_sub (
      .smp_i (smp[c]),
      .off_i (off[c]),
      .res_o (res[c])
    );
  end

  dl_settle_gate #(.SETTLE(SETTLE)) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vld_i     (sample_vld_i),
    .en_i      (ctl.en),
    .en_rise_i (ctl.en_rise),
    .cal_i     (ctl.cal),
    .fwd_o     (fwd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_o <= 1'b0;
      out_i_o   <= '0;
      out_q_o   <= '0;
    end else begin
      out_vld_o <= fwd;
      if (fwd) begin
        out_i_o <= res[0];
        out_q_o <= res[1];
      end
    end
  end
endmodule

// File: rtl/dl_offset_gate_chk.sv
module dl_offset_gate_chk #(
  parameter int unsigned SETTLE = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic dl_on_i,
  input logic cal_i,
  input logic ext_cal_i,
  input logic tx_en_i,
  input logic sample_vld_i,
  input logic path_on_o,
  input logic short_o,
  input logic out_vld_o
);
  logic       en_l, cal_l, en_prev, take, ok_q;
  int unsigned seen, seen_b;

  assign en_l   = tx_en_i & dl_on_i & path_on_o;
  assign cal_l  = cal_i & dl_on_i & path_on_o;
  assign take   = sample_vld_i & en_l & ~cal_l;
  assign seen_b = (en_l && !en_prev) ? 0 : seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_prev <= 1'b0;
      seen    <= 0;
      ok_q    <= 1'b0;
    end else begin
      en_prev <= en_l;
      ok_q    <= take && seen_b >= SETTLE;
      if (take && seen_b < SETTLE) seen <= seen_b + 1;
      else if (en_l)               seen <= seen_b;
    end
  end

  assert_short_needs_cal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_o |-> (cal_l && !ext_cal_i));

  assert_off_no_output_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !path_on_o |=> !out_vld_o);

  assert_settle_window_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o == ok_q);

  assert_vld_follows_input_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o |-> $past(sample_vld_i));

  assert_cal_drops_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_l |=> !out_vld_o);
endmodule

bind dl_offset_gate dl_offset_gate_chk #(.SETTLE(SETTLE)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .dl_on_i      (dl_on_i),
  .cal_i        (cal_i),
  .ext_cal_i    (ext_cal_i),
  .tx_en_i      (tx_en_i),
  .sample_vld_i (sample_vld_i),
  .path_on_o    (path_on_o),
  .short_o      (short_o),
  .out_vld_o    (out_vld_o)
);

// File: tb/dl_offset_gate_bench.sv
module dl_offset_gate_bench;
  localparam int W = 12;
  localparam int MAXV = 2047;
  localparam int MINV = -2048;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic path_act, win_pd_en, dl_on, cal, ext_cal, tx_en, vld;
  logic signed [W-1:0] si, sq;
  logic path_on_o, short_o, out_vld_o;
  logic signed [W-1:0] out_i_o, out_q_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // reference state
  int m_off [2];
  int m_acc [2];
  int m_ccnt, m_scnt;
  bit m_cal_prev, m_en_prev;
  bit e_vld;
  int e_i, e_q;

  always #5 clk = ~clk;

  dl_offset_gate u_dl_offset_gate (
    .clk_i (clk), .rst_ni (rst_ni),
    .path_act_i (path_act), .win_pd_en_i (win_pd_en), .dl_on_i (dl_on),
    .cal_i (cal), .ext_cal_i (ext_cal), .tx_en_i (tx_en),
    .sample_vld_i (vld), .sample_i_i (si), .sample_q_i (sq),
    .path_on_o (path_on_o), .short_o (short_o), .out_vld_o (out_vld_o),
    .out_i_o (out_i_o), .out_q_o (out_q_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic int f_sat(int d);
    if (d > MAXV) return MAXV;
    if (d < MINV) return MINV;
    return d;
  endfunction

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, got, exp, $time);
    end
  endtask

  task automatic set_ctl(bit a, bit w, bit d, bit c, bit x, bit e);
    path_act = a; win_pd_en = w; dl_on = d; cal = c; ext_cal = x; tx_en = e;
  endtask

  // one cycle: inputs already driven; predict, clock, compare
  task automatic tick(bit v, int i, int q);
    bit on, calq, enq, take, done;
    int cb, sb;
    int ab [2];
    int smp [2];
    vld = v; si = W'(i); sq = W'(q);
    smp[0] = i; smp[1] = q;
    #1;
    on   = path_act & (dl_on | ~win_pd_en);
    calq = cal & dl_on & on;
    enq  = tx_en & dl_on & on;
    chk("R2 path_on", path_on_o, on);
    chk("R4 short", short_o, calq & ~ext_cal);
    // settle gate
    sb   = (enq && !m_en_prev) ? 0 : m_scnt;
    take = v & enq & ~calq;
    done = sb >= 8;
    e_vld = take & done;
    if (e_vld) begin
      e_i = f_sat(i - m_off[0]);
      e_q = f_sat(q - m_off[1]);
    end
    if (take && !done) m_scnt = sb + 1;
    else if (enq)      m_scnt = sb;
    // calibration
    if (calq) begin
      cb = m_cal_prev ? m_ccnt : 0;
      ab[0] = m_cal_prev ? m_acc[0] : 0;
      ab[1] = m_cal_prev ? m_acc[1] : 0;
      if (v && cb < 16) begin
        m_acc[0] = ab[0] + i; m_acc[1] = ab[1] + q; m_ccnt = cb + 1;
      end else begin
        m_acc[0] = ab[0]; m_acc[1] = ab[1]; m_ccnt = cb;
      end
    end else if (m_cal_prev && m_ccnt == 16) begin
      m_off[0] = m_acc[0] >>> 4;
      m_off[1] = m_acc[1] >>> 4;
    end
    m_cal_prev = calq;
    m_en_prev  = enq;
    @(posedge clk);
    @(negedge clk);
    chk("R8 out_vld", out_vld_o, e_vld);
    chk("R6 out_i", out_i_o, e_i);
    chk("R6 out_q", out_q_o, e_q);
  endtask

  initial begin
    void'($urandom(32'd2024));
    set_ctl(1, 1, 0, 0, 0, 0);
    vld = 0; si = '0; sq = '0;
    m_off[0] = 0; m_off[1] = 0; m_acc[0] = 0; m_acc[1] = 0;
    m_ccnt = 0; m_scnt = 0; m_cal_prev = 0; m_en_prev = 0;
    e_vld = 0; e_i = 0; e_q = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset vld", out_vld_o, 0);
    chk("R1 reset i", out_i_o, 0);
    chk("R1 reset q", out_q_o, 0);
    rst_ni = 1'b1;

    // R2 truth table
    for (int k = 0; k < 8; k++) begin
      set_ctl(k[0], k[1], k[2], 0, 0, 0);
      tick(0, 0, 0);
      chk("R2 table", path_on_o, k[0] & (k[2] | ~k[1]));
    end

    // R4 modes
    set_ctl(1, 1, 1, 1, 0, 0); tick(0, 0, 0); chk("R4 internal short", short_o, 1);
    set_ctl(1, 1, 1, 1, 1, 0); tick(0, 0, 0); chk("R4 external no short", short_o, 0);
    set_ctl(1, 1, 0, 1, 0, 0); tick(0, 0, 0); chk("R4 dl off no short", short_o, 0);

    // R1 offset zero, R8 settle
    set_ctl(1, 1, 1, 0, 0, 1);
    for (int k = 0; k < 8; k++) begin
      tick(1, 100, -100);
      chk("R8 settle drop", out_vld_o, 0);
    end
    tick(1, 100, -100);
    chk("R1 zero offset i", out_i_o, 100);
    chk("R1 zero offset q", out_q_o, -100);
    tick(0, 7, 7);
    chk("R7 hold vld", out_vld_o, 0);
    chk("R7 hold data", out_i_o, 100);

    // R5 internal calibration: I sums to -1, Q to 640
    set_ctl(1, 1, 1, 1, 0, 0);
    for (int k = 0; k < 16; k++) tick(1, (k == 5) ? -1 : 0, 40);
    tick(1, 999, 999);                      // beyond 16, ignored
    set_ctl(1, 1, 1, 0, 0, 0); tick(0, 0, 0);
    set_ctl(1, 1, 1, 0, 0, 1);
    for (int k = 0; k < 8; k++) tick(1, 0, 0);
    tick(1, 5, 50);
    chk("R5 floor offset i", out_i_o, 6);
    chk("R5 offset q", out_q_o, 10);
    tick(1, 2047, -2048);
    chk("R6 sat high", out_i_o, 2047);
    chk("R6 sat low", out_q_o, -2048);

    // R9 cal during enable drops; short window keeps offset (R5)
    set_ctl(1, 1, 1, 1, 1, 1);
    for (int k = 0; k < 10; k++) begin
      tick(1, 500, 500);
      chk("R9 cal drop", out_vld_o, 0);
    end
    set_ctl(1, 1, 1, 0, 1, 1); tick(0, 0, 0);
    tick(1, 5, 50);
    chk("R5 short window keeps i", out_i_o, 6);
    chk("R5 short window keeps q", out_q_o, 10);

    // R3 dl off: cal and enable ignored
    set_ctl(1, 0, 0, 1, 0, 1);
    for (int k = 0; k < 20; k++) begin
      tick(1, 700, 700);
      chk("R3 no output", out_vld_o, 0);
    end
    // R8 restart after re-enable
    set_ctl(1, 1, 1, 0, 0, 1);
    for (int k = 0; k < 8; k++) begin
      tick(1, 9, 9);
      chk("R8 restart drop", out_vld_o, 0);
    end
    tick(1, 5, 50);
    chk("R3 offset untouched", out_i_o, 6);
    set_ctl(1, 1, 1, 0, 0, 0);
    tick(1, 5, 50);
    chk("R9 enable low drop", out_vld_o, 0);

    // random phase
    set_ctl(1, 1, 1, 0, 0, 0);
    for (int n = 0; n < 6000; n++) begin
      int ri, rq;
      if ($urandom_range(0, 39) == 0) cal = ~cal;
      if ($urandom_range(0, 29) == 0) tx_en = ~tx_en;
      if ($urandom_range(0, 99) == 0) dl_on = ~dl_on;
      if ($urandom_range(0, 199) == 0) path_act = ~path_act;
      if ($urandom_range(0, 149) == 0) win_pd_en = ~win_pd_en;
      if ($urandom_range(0, 59) == 0) ext_cal = ~ext_cal;
      if ($urandom_range(0, 3) == 0) begin
        ri = int'($urandom_range(0, 4095)) - 2048;
        rq = int'($urandom_range(0, 4095)) - 2048;
      end else begin
        ri = int'($urandom_range(0, 200)) - 100;
        rq = int'($urandom_range(0, 200)) - 100;
      end
      tick($urandom_range(0, 3) != 0, ri, rq);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule